// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a small processor core that runs in several operating modes. Software always addresses registers 0 to 15, but the physical register behind a number depends on the mode: the low eight registers and the program counter (register 15) exist once, the fast-interrupt mode substitutes its own registers 8 to 14, and the interrupt, supervisor, abort and undefined-instruction modes each substitute only their own stack pointer (13) and link register (14). User and system mode share the base bank.

Each exception mode also owns a saved status word. The current mode's saved status is presented at an output and can be written through a dedicated port. A second write path, meant for the controller that performs exception entry, loads the link register and saved status of a chosen target mode in one cycle, independently of the mode the core is in at that moment. Two combinational read ports and one clocked write port serve the datapath; the program counter is brought out on its own output.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-low reset clears every physical register and every saved status word to zero; all reads return zero afterwards until written.
- R2: Registers 0 to 7 are one physical set: a write in any mode is seen by a read of the same number in every other mode.
- R3: In fast-interrupt mode (mode code 10001) registers 8 to 14 map to a private set; writes there leave the user-bank registers 8 to 14 unchanged, and vice versa.
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private registers 13 and 14 only; their registers 8 to 12 are the user-bank registers.
- R5: Register 15 is a single physical register in every mode, and its value is always present on `pc_out`.
- R6: System mode (11111), user mode (10000) and any mode code not listed in R3 or R4 all use the user bank.
- R7: Reads are combinational from the current `mode` and address; a register write lands in the bank selected by the `mode` value present at the same clock edge.
- R8: Each of the five exception modes has its own saved status word, shown on `spsr_out` while that mode is current and written by `spsr_wr_en`; in user, system or unlisted modes `spsr_out` is zero and `spsr_wr_en` has no effect.
- R9: When `xcpt_en` is high and `xcpt_mode` is one of the five exception modes, the clock edge writes `xcpt_lr` into that mode's register 14 and `xcpt_spsr` into its saved status, whatever the current mode; for any other `xcpt_mode` the port has no effect.
- R10: If the exception port and a normal write port hit the same register or saved status word on one edge, the exception port's value is kept.
- R11: The two read ports are independent; both may address the same register in the same cycle and each returns its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 5 | Current operating mode code |
| rd_addr_a | input | 4 | Read port A register number |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register number |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| spsr_wr_en | input | 1 | Write the current mode's saved status |
| spsr_wr_data | input | 32 | Saved status write data |
| xcpt_en | input | 1 | Exception-entry write enable |
| xcpt_mode | input | 5 | Target mode of the exception-entry write |
| xcpt_lr | input | 32 | Value for the target mode's register 14 |
| xcpt_spsr | input | 32 | Value for the target mode's saved status |
| pc_out | output | 32 | Register 15 |
| spsr_out | output | 32 | Saved status of the current mode, zero if none |

## Verification
The bench builds the block with its default 32-bit data width, the only width the status layout and the mode encoding fit, so every bank of all seven modes plus one unlisted code is reachable and each physical register can be given a distinct value. With that width, writing a recognisable pattern into each bank and reading all sixteen numbers from every mode exposes any wrong entry in the logical-to-physical map, and simultaneous normal and exception writes to the same location show which port wins.

// File: rtl/rf_pkg.sv
// Package: shared constants and types for the banked register file.
// Assumes the fixed 16-register architecture with 5-bit mode codes.
package rf_pkg;
    localparam int MODE_W  = 5;
    localparam int REG_N   = 16;
    localparam int REG_AW  = $clog2(REG_N);

    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int XBANK_N   = 5;               // banks that own a saved status
    localparam int FIQ_FIRST = 8;
    localparam int SP_IDX    = 13;
    localparam int LR_IDX    = 14;
    localparam int PC_IDX    = 15;
    localparam int FIQ_CNT   = LR_IDX - FIQ_FIRST + 1;
    localparam int PAIR_CNT  = LR_IDX - SP_IDX + 1;
    localparam int PAIR_BANKS = XBANK_N - 1;
    localparam int FIQ_BASE  = REG_N;
    localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;
    localparam int PHYS_N    = PAIR_BASE + PAIR_BANKS * PAIR_CNT;
    localparam int PHYS_AW   = $clog2(PHYS_N);
endpackage

// File: rtl/rf_mode_decode.sv
// Module: rf_mode_decode
// Turns a 5-bit mode code into a bank selector and a flag telling whether
// the mode owns a saved status word. Unlisted codes fall back to the user bank.
module rf_mode_decode
    import rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              priv
);
    // Decode the mode code to a bank
    always_comb begin
        priv = 1'b1;
        unique case (mode)
            MD_FIQ:  bank = BK_FIQ;
            MD_IRQ:  bank = BK_IRQ;
            MD_SVC:  bank = BK_SVC;
            MD_ABT:  bank = BK_ABT;
            MD_UND:  bank = BK_UND;
            default: begin
                bank = BK_USR;
                priv = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rf_addr_map.sv
// Module: rf_addr_map
// Maps a logical register number and a bank to a physical index.
// Layout: 0..15 base bank, then the seven fast-interrupt registers, then
// one stack-pointer/link pair per remaining exception bank.
module rf_addr_map
    import rf_pkg::*;
(
    input  bank_e              bank,
    input  logic [REG_AW-1:0]  lreg,
    output logic [PHYS_AW-1:0] pidx
);
    // Compute the physical slot for this register number
    always_comb begin
        int r;
        int idx;
        r   = int'(lreg);
        idx = r;
        if (bank == BK_FIQ && r >= FIQ_FIRST && r <= LR_IDX) begin
            idx = FIQ_BASE + (r - FIQ_FIRST);
        end else if (bank != BK_USR && bank != BK_FIQ && r >= SP_IDX && r <= LR_IDX) begin
            idx = PAIR_BASE + (int'(bank) - int'(BK_IRQ)) * PAIR_CNT + (r - SP_IDX);
        end
        pidx = PHYS_AW'(idx);
    end
endmodule

// File: rtl/rf_storage.sv
// Module: rf_storage
// Flat physical register array with two combinational reads, a fixed read
// of the program counter slot and two write ports; port B wins on a clash.
module rf_storage
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHYS_AW-1:0] rd_idx_a,
    output logic [DATA_W-1:0]  rd_data_a,
    input  logic [PHYS_AW-1:0] rd_idx_b,
    output logic [DATA_W-1:0]  rd_data_b,
    output logic [DATA_W-1:0]  pc_data,
    input  logic               wa_en,
    input  logic [PHYS_AW-1:0] wa_idx,
    input  logic [DATA_W-1:0]  wa_data,
    input  logic               wb_en,
    input  logic [PHYS_AW-1:0] wb_idx,
    input  logic [DATA_W-1:0]  wb_data
);
    logic [DATA_W-1:0] mem_q [PHYS_N];

    // Update the array, priority port wins
    always_ff @(posedge clk) begin
        for (int i = 0; i < PHYS_N; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wb_en && int'(wb_idx) == i) begin
                mem_q[i] <= wb_data;
            end else if (wa_en && int'(wa_idx) == i) begin
                mem_q[i] <= wa_data;
            end
        end
    end

    // Read port A
    always_comb rd_data_a = (int'(rd_idx_a) < PHYS_N) ? mem_q[rd_idx_a] : '0;
    // Read port B
    always_comb rd_data_b = (int'(rd_idx_b) < PHYS_N) ? mem_q[rd_idx_b] : '0;
    // Program counter slot
    always_comb pc_data = mem_q[PC_IDX];
endmodule

// File: rtl/rf_spsr_bank.sv
// Module: rf_spsr_bank
// One saved status word per exception bank. The current-mode port and the
// exception-entry port write it; the exception port wins on a clash.
// Banks without a saved status read as zero and ignore writes.
module rf_spsr_bank
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             cur_bank,
    input  logic              cur_priv,
    input  logic              cur_wr_en,
    input  logic [DATA_W-1:0] cur_wr_data,
    input  bank_e             x_bank,
    input  logic              x_priv,
    input  logic              x_wr_en,
    input  logic [DATA_W-1:0] x_wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sts_q [XBANK_N];
    logic [XBANK_N-1:0] cur_hit;
    logic [XBANK_N-1:0] x_hit;

    // Per-bank write selects
    for (genvar g = 0; g < XBANK_N; g++) begin : g_sel
        assign cur_hit[g] = cur_wr_en && cur_priv && (int'(cur_bank) == g + 1);
        assign x_hit[g]   = x_wr_en && x_priv && (int'(x_bank) == g + 1);
    end

    // Store saved status words
    always_ff @(posedge clk) begin
        for (int i = 0; i < XBANK_N; i++) begin
            if (!rst_n) begin
                sts_q[i] <= '0;
            end else if (x_hit[i]) begin
                sts_q[i] <= x_wr_data;
            end else if (cur_hit[i]) begin
                sts_q[i] <= cur_wr_data;
            end
        end
    end

    // Present the current bank's word
    always_comb begin
        rd_data = '0;
        if (cur_priv) rd_data = sts_q[int'(cur_bank) - 1];
    end
endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// Mode-banked register file: decodes the current and exception-target modes,
// maps four register numbers to physical slots, and drives the storage and
// saved-status banks. Assumes DATA_W matches the status word width.
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode,
    input  logic [REG_AW-1:0]   rd_addr_a,
    output logic [DATA_W-1:0]   rd_data_a,
    input  logic [REG_AW-1:0]   rd_addr_b,
    output logic [DATA_W-1:0]   rd_data_b,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                spsr_wr_en,
    input  logic [DATA_W-1:0]   spsr_wr_data,
    input  logic                xcpt_en,
    input  logic [MODE_W-1:0]   xcpt_mode,
    input  logic [DATA_W-1:0]   xcpt_lr,
    input  logic [DATA_W-1:0]   xcpt_spsr,
    output logic [DATA_W-1:0]   pc_out,
    output logic [DATA_W-1:0]   spsr_out
);
    localparam int MAP_N = 4;   // read A, read B, write, exception link
    localparam int MAP_XLR = 3;

    bank_e cur_bank;
    logic  cur_priv;
    bank_e x_bank;
    logic  x_priv;

    bank_e              map_bank [MAP_N];
    logic [REG_AW-1:0]  map_lreg [MAP_N];
    logic [PHYS_AW-1:0] map_pidx [MAP_N];

    rf_mode_decode u_cur_dec (
        .mode (mode),
        .bank (cur_bank),
        .priv (cur_priv)
    );

    rf_mode_decode u_x_dec (
        .mode (xcpt_mode),
        .bank (x_bank),
        .priv (x_priv)
    );

    // Select bank and register number for each mapper
    always_comb begin
        map_bank[0] = cur_bank;  map_lreg[0] = rd_addr_a;
        map_bank[1] = cur_bank;  map_lreg[1] = rd_addr_b;
        map_bank[2] = cur_bank;  map_lreg[2] = wr_addr;
        map_bank[MAP_XLR] = x_bank;
        map_lreg[MAP_XLR] = REG_AW'(LR_IDX);
    end

    for (genvar g = 0; g < MAP_N; g++) begin : g_map
        rf_addr_map u_map (
            .bank (map_bank[g]),
            .lreg (map_lreg[g]),
            .pidx (map_pidx[g])
        );
    end

    rf_storage #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_a  (map_pidx[0]),
        .rd_data_a (rd_data_a),
        .rd_idx_b  (map_pidx[1]),
        .rd_data_b (rd_data_b),
        .pc_data   (pc_out),
        .wa_en     (wr_en),
        .wa_idx    (map_pidx[2]),
        .wa_data   (wr_data),
        .wb_en     (xcpt_en && x_priv),
        .wb_idx    (map_pidx[MAP_XLR]),
        .wb_data   (xcpt_lr)
    );

    rf_spsr_bank #(.DATA_W(DATA_W)) u_spsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_bank    (cur_bank),
        .cur_priv    (cur_priv),
        .cur_wr_en   (spsr_wr_en),
        .cur_wr_data (spsr_wr_data),
        .x_bank      (x_bank),
        .x_priv      (x_priv),
        .x_wr_en     (xcpt_en),
        .x_wr_data   (xcpt_spsr),
        .rd_data     (spsr_out)
    );
endmodule

// File: rtl/banked_regfile_chk.sv
// Module: banked_regfile_chk
// Property checker bound to banked_regfile. Armed one cycle after reset
// is released so that no property looks back into the reset period.
module banked_regfile_chk
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [REG_AW-1:0] rd_addr_a,
    input  logic [DATA_W-1:0] rd_data_a,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xcpt_en,
    input  logic [MODE_W-1:0] xcpt_mode,
    input  logic [DATA_W-1:0] xcpt_spsr,
    input  logic [DATA_W-1:0] pc_out,
    input  logic [DATA_W-1:0] spsr_out
);
    logic armed;

    // Arm after the first cycle out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic x_target_ok;
    assign x_target_ok = (xcpt_mode == MD_FIQ) || (xcpt_mode == MD_IRQ) ||
                         (xcpt_mode == MD_SVC) || (xcpt_mode == MD_ABT) ||
                         (xcpt_mode == MD_UND);

    // R2
    shared_low_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && int'(wr_addr) < FIQ_FIRST) |=>
        (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

    // R5
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && int'(wr_addr) == PC_IDX) |=> (pc_out == $past(wr_data)));

    // R5
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !(wr_en && int'(wr_addr) == PC_IDX)) |=> $stable(pc_out));

    // R8
    no_saved_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (mode == MD_USR || mode == MD_SYS)) |-> (spsr_out == '0));

    // R9
    xcpt_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && xcpt_en && x_target_ok) |=>
        (mode != $past(xcpt_mode) || spsr_out == $past(xcpt_spsr)));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xcpt_en   (xcpt_en),
    .xcpt_mode (xcpt_mode),
    .xcpt_spsr (xcpt_spsr),
    .pc_out    (pc_out),
    .spsr_out  (spsr_out)
);

// File: tb/banked_regfile_tb_top.sv
// Bench: behavioural key/value reference model of the banked register file,
// updated at each rising edge and compared on every falling edge.
module banked_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    localparam logic [4:0] C_USR = 5'b10000;
    localparam logic [4:0] C_FIQ = 5'b10001;
    localparam logic [4:0] C_IRQ = 5'b10010;
    localparam logic [4:0] C_SVC = 5'b10011;
    localparam logic [4:0] C_ABT = 5'b10111;
    localparam logic [4:0] C_UND = 5'b11011;
    localparam logic [4:0] C_SYS = 5'b11111;
    localparam logic [4:0] C_BAD = 5'b00000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [4:0]    mode;
    logic [3:0]    rd_addr_a, rd_addr_b, wr_addr;
    logic [DW-1:0] rd_data_a, rd_data_b, wr_data;
    logic          wr_en, spsr_wr_en, xcpt_en;
    logic [DW-1:0] spsr_wr_data, xcpt_lr, xcpt_spsr, pc_out, spsr_out;
    logic [4:0]    xcpt_mode;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    logic [DW-1:0] m_reg  [int];
    logic [DW-1:0] m_stat [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data),
        .xcpt_en(xcpt_en), .xcpt_mode(xcpt_mode),
        .xcpt_lr(xcpt_lr), .xcpt_spsr(xcpt_spsr),
        .pc_out(pc_out), .spsr_out(spsr_out)
    );

    // Exception modes keep their own code; everything else acts as user
    function automatic int norm(logic [4:0] m);
        if (m == C_FIQ || m == C_IRQ || m == C_SVC || m == C_ABT || m == C_UND)
            return int'(m);
        return int'(C_USR);
    endfunction

    // Storage key of register r as seen from mode m
    function automatic int key(logic [4:0] m, int r);
        int nm = norm(m);
        if (nm == int'(C_FIQ) && r >= 8 && r <= 14) return 1000 + r;
        if (nm != int'(C_USR) && nm != int'(C_FIQ) && (r == 13 || r == 14))
            return nm * 100 + r;
        return r;
    endfunction

    function automatic logic [DW-1:0] mget(int k);
        return m_reg.exists(k) ? m_reg[k] : '0;
    endfunction

    function automatic logic [DW-1:0] sget(logic [4:0] m);
        int nm = norm(m);
        if (nm == int'(C_USR)) return '0;
        return m_stat.exists(nm) ? m_stat[nm] : '0;
    endfunction

    task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("rd_data_a", rd_data_a, mget(key(mode, int'(rd_addr_a))));
        chk("rd_data_b", rd_data_b, mget(key(mode, int'(rd_addr_b))));
        chk("pc_out",    pc_out,    mget(15));
        chk("spsr_out",  spsr_out,  sget(mode));
    endtask

    // One clock: update the model at the rising edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        if (!rst_n) begin
            m_reg.delete();
            m_stat.delete();
        end else begin
            if (wr_en) m_reg[key(mode, int'(wr_addr))] = wr_data;
            if (spsr_wr_en && norm(mode) != int'(C_USR)) m_stat[norm(mode)] = spsr_wr_data;
            if (xcpt_en && norm(xcpt_mode) != int'(C_USR)) begin
                m_reg[key(xcpt_mode, 14)] = xcpt_lr;
                m_stat[norm(xcpt_mode)]   = xcpt_spsr;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        wr_en = 1'b0; spsr_wr_en = 1'b0; xcpt_en = 1'b0;
    endtask

    task automatic wr(logic [4:0] m, int a, logic [DW-1:0] d);
        mode = m; wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        cyc();
        idle();
    endtask

    task automatic rd(logic [4:0] m, int a, int b);
        mode = m; rd_addr_a = 4'(a); rd_addr_b = 4'(b);
        cyc();
    endtask

    task automatic read_all(logic [4:0] m);
        for (int i = 0; i < 16; i++) rd(m, i, 15 - i);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [4:0] xm [5];
        xm[0] = C_FIQ; xm[1] = C_IRQ; xm[2] = C_SVC; xm[3] = C_ABT; xm[4] = C_UND;
        rst_n = 1'b0; mode = C_USR; rd_addr_a = '0; rd_addr_b = '0;
        wr_addr = '0; wr_data = '0; spsr_wr_data = '0;
        xcpt_mode = C_USR; xcpt_lr = '0; xcpt_spsr = '0;
        idle();

        // R1: reset state
        cur_req = "R1";
        cyc(); cyc();
        rst_n = 1'b1;
        read_all(C_USR);

        // R2 / R5: fill the user bank, read back in user mode
        cur_req = "R2";
        for (int i = 0; i < 16; i++) wr(C_USR, i, 32'h1000_0000 + 32'(i));
        read_all(C_USR);

        // R3: fast-interrupt bank private copies of 8..14
        cur_req = "R3";
        read_all(C_FIQ);
        for (int i = 8; i < 15; i++) wr(C_FIQ, i, 32'hF100_0000 + 32'(i));
        read_all(C_FIQ);
        read_all(C_USR);

        // R4: pair banks, and 8..12 shared with user
        cur_req = "R4";
        for (int b = 1; b < 5; b++) begin
            wr(xm[b], 13, 32'hA000_0013 + 32'(b << 8));
            wr(xm[b], 14, 32'hA000_0014 + 32'(b << 8));
            wr(xm[b], 8 + b, 32'hB000_0000 + 32'(b));
            read_all(xm[b]);
        end
        read_all(C_USR);
        read_all(C_FIQ);

        // R2: low register written in an exception mode, read everywhere
        cur_req = "R2";
        wr(C_UND, 3, 32'h3333_0003);
        for (int b = 0; b < 5; b++) rd(xm[b], 3, 7);
        rd(C_USR, 3, 3);

        // R5: program counter shared, written from interrupt mode
        cur_req = "R5";
        wr(C_IRQ, 15, 32'h0000_8000);
        for (int b = 0; b < 5; b++) rd(xm[b], 15, 0);
        rd(C_SYS, 15, 15);

        // R6: system and unlisted codes use user bank
        cur_req = "R6";
        read_all(C_SYS);
        wr(C_SYS, 13, 32'h5555_0013);
        rd(C_USR, 13, 14);
        read_all(C_BAD);
        wr(C_BAD, 9, 32'h5555_0009);
        rd(C_USR, 9, 13);

        // R7: mode changes on the write edge, reads follow mode at once
        cur_req = "R7";
        rd(C_USR, 13, 14);
        wr(C_SVC, 13, 32'h7777_0013);
        rd(C_USR, 13, 13);
        rd(C_SVC, 13, 13);

        // R8: saved status per exception mode, none in user/system
        cur_req = "R8";
        for (int b = 0; b < 5; b++) begin
            mode = xm[b]; spsr_wr_en = 1'b1; spsr_wr_data = 32'h6000_0010 + 32'(b);
            cyc(); idle();
        end
        for (int b = 0; b < 5; b++) rd(xm[b], 0, 1);
        mode = C_USR; spsr_wr_en = 1'b1; spsr_wr_data = 32'hDEAD_0001; cyc(); idle();
        mode = C_SYS; spsr_wr_en = 1'b1; spsr_wr_data = 32'hDEAD_0002; cyc(); idle();
        for (int b = 0; b < 5; b++) rd(xm[b], 0, 1);
        rd(C_USR, 0, 1);

        // R9: exception entry port from user mode into each target
        cur_req = "R9";
        for (int b = 0; b < 5; b++) begin
            mode = C_USR; xcpt_en = 1'b1; xcpt_mode = xm[b];
            xcpt_lr = 32'hE000_0014 + 32'(b); xcpt_spsr = 32'h9000_0000 + 32'(b);
            cyc(); idle();
            rd(xm[b], 14, 13);
        end
        mode = C_FIQ; xcpt_en = 1'b1; xcpt_mode = C_USR;
        xcpt_lr = 32'hBAD0_0014; xcpt_spsr = 32'hBAD0_5555; cyc(); idle();
        rd(C_USR, 14, 13);
        xcpt_en = 1'b1; xcpt_mode = C_SYS; cyc(); idle();
        rd(C_SYS, 14, 14);

        // R10: exception port wins over normal write and status write
        cur_req = "R10";
        mode = C_ABT; wr_en = 1'b1; wr_addr = 4'd14; wr_data = 32'h1111_1111;
        spsr_wr_en = 1'b1; spsr_wr_data = 32'h2222_2222;
        xcpt_en = 1'b1; xcpt_mode = C_ABT; xcpt_lr = 32'h3333_3333; xcpt_spsr = 32'h4444_4444;
        cyc(); idle();
        rd(C_ABT, 14, 13);
        mode = C_FIQ; wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'h5151_0013;
        xcpt_en = 1'b1; xcpt_mode = C_FIQ; xcpt_lr = 32'h5151_0014; xcpt_spsr = 32'h5151_5555;
        cyc(); idle();
        rd(C_FIQ, 13, 14);

        // R11: both ports on the same register
        cur_req = "R11";
        for (int i = 0; i < 16; i++) rd(C_IRQ, i, i);

        // R1: reset after data has been written
        cur_req = "R1";
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        read_all(C_FIQ);
        for (int b = 1; b < 5; b++) rd(xm[b], 13, 14);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule